// File: doc/BRIEF.md
# Configurable Format UART Transmitter

This block turns bytes offered on a valid/ready port into asynchronous serial frames on one transmit line. Each frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period of one, one and a half or two bit times. The line rests high between frames. The bit time comes from an integer divider and a ×1/×4 prescaler applied to the system clock. The divider and prescaler values are inputs. Working them out from a requested rate is left to the surrounding logic.

The transmitter can also hold the line low as a line break. A break lasts a set number of milliseconds, or it lasts until a stop pulse arrives. A busy flag and two one-cycle strobes let nearby control logic follow the frames: one strobe marks the start bit and the other marks the end of the stop period. Neighbours use them for activity indicators or for transceiver direction control. Format settings are captured when a frame or break begins, so changing them while the line is busy does not disturb the frame in progress.

Top module: `cfg_uart_tx`

## Requirements
- R1: After reset and while idle, `tx_o` is 1, `busy_o` is 0, `ready_o` is 1, and both strobes are 0.
- R2: A frame starts with one low start bit. The data bits follow, least significant bit first. The data length is `cfg_len_i`+5, with encoding 0=5, 1=6, 2=7 and 3=8 bits, and the unused high bits of `data_i` are ignored.
- R3: The parity mode `cfg_par_i` selects the bit after the data. 0 sends no parity bit. 1 (even) makes the count of ones in the data and parity bits even. 2 (odd) makes that count odd. 3 (mark) sends a 1, and 4 (space) sends a 0.
- R4: The stop period is high. `cfg_stop_i` selects its length: 0 gives 1 bit time, 2 gives 2 bit times, and 1 gives 1.5 bit times, but only when the data length is 5. With any other data length, code 1 gives 1 bit time.
- R5: One bit time is 2×P×D clock cycles. D is `cfg_div_i`, with 0 treated as 1. P is 4 when `cfg_pre4_i` is 1 and 1 otherwise. The half bit of a 1.5 stop period is P×D cycles.
- R6: The format, divider and prescaler are captured in the cycle a byte is accepted. Changing them while a frame is in progress has no effect on that frame.
- R7: `sof_o` pulses in the first cycle of the start bit. `eos_o` pulses in the last cycle of the stop period. `busy_o` is 1 from the first start-bit cycle through the last stop cycle, and `ready_o` is 0 during that time.
- R8: A break requested with `brk_ms_i` from 1 to 125 holds `tx_o` low for `brk_ms_i`×MS_CYCLES cycles, beginning in the cycle after `brk_start_i` is seen while idle. Values above 125 act as 125.
- R9: A break requested with `brk_ms_i`=0 holds `tx_o` low until `brk_stop_i` is seen. `tx_o` goes high in the next cycle. A break never raises `sof_o`.
- R10: A break request that arrives during a frame waits until the frame has finished. `ready_o` is 0 while the request waits. The break begins one idle cycle after the stop period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | Byte offered |
| ready_o | output | 1 | Byte accepted when high together with valid_i |
| cfg_len_i | input | 2 | Data length code (0..3 = 5..8 bits) |
| cfg_par_i | input | 3 | Parity mode code |
| cfg_stop_i | input | 2 | Stop length code |
| cfg_div_i | input | DIV_W | Bit time divider D |
| cfg_pre4_i | input | 1 | Prescaler ×4 select |
| brk_start_i | input | 1 | Break request pulse |
| brk_ms_i | input | 7 | Break length in ms, 0 means open-ended |
| brk_stop_i | input | 1 | Ends a break |
| tx_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | Frame or break in progress |
| sof_o | output | 1 | Start-of-frame strobe |
| eos_o | output | 1 | End-of-stop strobe |

## Verification
A divider count that is wrong by even one cycle moves every later edge of the frame. The error therefore shows at the port within the first bit time and grows across the frame. Because of this, `tx_o` is compared with a frame built in the bench on every cycle, not only at bit centres. An error in the bit counter or the parity state adds or removes a whole bit time. The `eos_o` strobe and the drop of `busy_o` then land in the wrong cycle, and those are checked on their exact cycle. An error in the break counter changes how long the line stays low, which is checked at the last low cycle and at the first cycle after it.

// File: rtl/cfg_uart_tx_pkg.sv
`timescale 1ns/1ps
package cfg_uart_tx_pkg;
  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_EVEN  = 3'd1,
    PAR_ODD   = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } par_e;

  typedef enum logic [1:0] {
    STOP_ONE  = 2'd0,
    STOP_HALF = 2'd1,
    STOP_TWO  = 2'd2
  } stop_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP1 = 3'd4,
    ST_STOP2 = 3'd5,
    ST_BRK   = 3'd6
  } tx_state_e;

  localparam int unsigned BRK_MS_MAX = 125;
endpackage

// File: rtl/uart_bit_timer.sv
`timescale 1ns/1ps
module uart_bit_timer #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             half_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             pre4_i,
  output logic             tick_o
);
  localparam int unsigned CW = DIV_W + 3;

  logic [CW-1:0] div_eff, lim_full, lim, cnt_q;

  always_comb begin
    div_eff  = (div_i == '0) ? CW'(1) : CW'(div_i);
    lim_full = pre4_i ? (div_eff << 3) : (div_eff << 1);
    lim      = half_i ? (lim_full >> 1) : lim_full;
  end

  assign tick_o = en_i && (cnt_q == lim - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  AST_CNT_BELOW_LIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q < lim)) else $error("bit timer overran its limit"); // R5
endmodule

// File: rtl/uart_brk_timer.sv
`timescale 1ns/1ps
module uart_brk_timer #(
  parameter int unsigned MS_CYCLES = 48000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [6:0] ms_i,
  output logic       done_o
);
  import cfg_uart_tx_pkg::*;
  localparam int unsigned CYW = $clog2(MS_CYCLES + 1);

  logic [CYW-1:0] cyc_q;
  logic [6:0]     ms_q, len_q, len_in;

  assign len_in = (ms_i > 7'(BRK_MS_MAX)) ? 7'(BRK_MS_MAX) : ms_i;
  assign done_o = en_i && (len_q != '0) && (ms_q == len_q - 7'd1)
                  && (cyc_q == CYW'(MS_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      ms_q  <= '0;
      len_q <= '0;
    end else if (!en_i) begin
      cyc_q <= '0;
      ms_q  <= '0;
      len_q <= len_in;
    end else if (cyc_q == CYW'(MS_CYCLES - 1)) begin
      cyc_q <= '0;
      if (len_q != '0) ms_q <= ms_q + 7'd1;
    end else begin
      cyc_q <= cyc_q + CYW'(1);
    end
  end

  AST_BRK_MS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && len_q != '0) |-> (ms_q < len_q)) else $error("break ms count past length"); // R8
endmodule

// File: rtl/uart_tx_seq.sv
`timescale 1ns/1ps
module uart_tx_seq #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       data_i,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [1:0]       cfg_len_i,
  input  logic [2:0]       cfg_par_i,
  input  logic [1:0]       cfg_stop_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic             cfg_pre4_i,
  input  logic             brk_start_i,
  input  logic             brk_stop_i,
  input  logic             tick_i,
  input  logic             brk_done_i,
  output logic             tmr_en_o,
  output logic             tmr_half_o,
  output logic [DIV_W-1:0] div_o,
  output logic             pre4_o,
  output logic             brk_en_o,
  output logic             tx_o,
  output logic             busy_o,
  output logic             sof_o,
  output logic             eos_o
);
  import cfg_uart_tx_pkg::*;

  tx_state_e        state_q;
  logic [7:0]       sh_q;
  logic [2:0]       bit_cnt_q;
  logic [1:0]       len_q;
  par_e             par_q;
  stop_e            stop_q;
  logic [DIV_W-1:0] div_q;
  logic             pre4_q, pbit_q, pend_q, sof_q;
  logic [7:0]       mask, dmask;
  logic             need2, brk_req, pbit_d;
  logic [2:0]       last_bit;

  assign mask     = 8'hFF >> (2'd3 - cfg_len_i);
  assign dmask    = data_i & mask;
  assign last_bit = 3'd4 + {1'b0, len_q};
  assign need2    = (stop_q == STOP_TWO) || (stop_q == STOP_HALF && len_q == 2'd0);
  assign brk_req  = brk_start_i || pend_q;

  always_comb begin
    case (par_e'(cfg_par_i))
      PAR_EVEN: pbit_d = ^dmask;
      PAR_ODD:  pbit_d = ~^dmask;
      PAR_MARK: pbit_d = 1'b1;
      default:  pbit_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sh_q      <= '0;
      bit_cnt_q <= '0;
      len_q     <= '0;
      par_q     <= PAR_NONE;
      stop_q    <= STOP_ONE;
      div_q     <= '0;
      pre4_q    <= 1'b0;
      pbit_q    <= 1'b0;
      sof_q     <= 1'b0;
    end else begin
      sof_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (brk_req) begin
            state_q <= ST_BRK;
          end else if (valid_i) begin
            state_q   <= ST_START;
            sh_q      <= dmask;
            bit_cnt_q <= '0;
            len_q     <= cfg_len_i;
            par_q     <= (cfg_par_i > 3'd4) ? PAR_NONE : par_e'(cfg_par_i);
            stop_q    <= (cfg_stop_i == 2'd3) ? STOP_ONE : stop_e'(cfg_stop_i);
            div_q     <= cfg_div_i;
            pre4_q    <= cfg_pre4_i;
            pbit_q    <= pbit_d;
            sof_q     <= 1'b1;
          end
        end
        ST_START: if (tick_i) state_q <= ST_DATA;
        ST_DATA: if (tick_i) begin
          sh_q      <= sh_q >> 1;
          bit_cnt_q <= bit_cnt_q + 3'd1;
          if (bit_cnt_q == last_bit)
            state_q <= (par_q != PAR_NONE) ? ST_PAR : ST_STOP1;
        end
        ST_PAR:   if (tick_i) state_q <= ST_STOP1;
        ST_STOP1: if (tick_i) state_q <= need2 ? ST_STOP2 : ST_IDLE;
        ST_STOP2: if (tick_i) state_q <= ST_IDLE;
        ST_BRK:   if (brk_done_i || brk_stop_i) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // break request raised mid-frame is held until the line is idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                pend_q <= 1'b0;
    else if (brk_stop_i || state_q == ST_IDLE) pend_q <= 1'b0;
    else if (brk_start_i && state_q != ST_BRK) pend_q <= 1'b1;
  end

  always_comb begin
    unique case (state_q)
      ST_START: tx_o = 1'b0;
      ST_DATA:  tx_o = sh_q[0];
      ST_PAR:   tx_o = pbit_q;
      ST_BRK:   tx_o = 1'b0;
      default:  tx_o = 1'b1;
    endcase
  end

  assign tmr_en_o   = (state_q != ST_IDLE) && (state_q != ST_BRK);
  assign tmr_half_o = (state_q == ST_STOP2) && (stop_q == STOP_HALF);
  assign div_o      = div_q;
  assign pre4_o     = pre4_q;
  assign brk_en_o   = (state_q == ST_BRK);
  assign busy_o     = (state_q != ST_IDLE);
  assign ready_o    = (state_q == ST_IDLE) && !pend_q && !brk_start_i;
  assign sof_o      = sof_q;
  assign eos_o      = tick_i && (((state_q == ST_STOP1) && !need2) || (state_q == ST_STOP2));

  AST_SOF_LINE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> !tx_o) else $error("sof without start bit"); // R7
  AST_EOS_THEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_o |=> !busy_o) else $error("busy after end of stop"); // R7
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_en_o && !tick_i) |=> (state_q == $past(state_q))) else $error("bit advanced without tick"); // R5
  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(len_q) && $stable(div_q) && $stable(par_q)))
    else $error("format changed mid-frame"); // R6
  AST_NO_SOF_IN_BRK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_en_o |-> !sof_o) else $error("sof during break"); // R9
  AST_NO_ACCEPT_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !ready_o) else $error("ready while break pending"); // R10
endmodule

// File: rtl/cfg_uart_tx.sv
`timescale 1ns/1ps
module cfg_uart_tx #(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned MS_CYCLES = 48000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       data_i,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [1:0]       cfg_len_i,
  input  logic [2:0]       cfg_par_i,
  input  logic [1:0]       cfg_stop_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic             cfg_pre4_i,
  input  logic             brk_start_i,
  input  logic [6:0]       brk_ms_i,
  input  logic             brk_stop_i,
  output logic             tx_o,
  output logic             busy_o,
  output logic             sof_o,
  output logic             eos_o
);
  logic             tick, brk_done, tmr_en, tmr_half, pre4, brk_en;
  logic [DIV_W-1:0] div;

  uart_tx_seq #(.DIV_W(DIV_W)) seq_i (
    .clk_i, .rst_ni, .data_i, .valid_i, .ready_o,
    .cfg_len_i, .cfg_par_i, .cfg_stop_i, .cfg_div_i, .cfg_pre4_i,
    .brk_start_i, .brk_stop_i,
    .tick_i(tick), .brk_done_i(brk_done),
    .tmr_en_o(tmr_en), .tmr_half_o(tmr_half), .div_o(div), .pre4_o(pre4),
    .brk_en_o(brk_en), .tx_o, .busy_o, .sof_o, .eos_o
  );

  uart_bit_timer #(.DIV_W(DIV_W)) bit_tmr_i (
    .clk_i, .rst_ni, .en_i(tmr_en), .half_i(tmr_half),
    .div_i(div), .pre4_i(pre4), .tick_o(tick)
  );

  uart_brk_timer #(.MS_CYCLES(MS_CYCLES)) brk_tmr_i (
    .clk_i, .rst_ni, .en_i(brk_en), .ms_i(brk_ms_i), .done_o(brk_done)
  );
endmodule

// File: tb/cfg_uart_tx_tb_top.sv
`timescale 1ns/1ps
module cfg_uart_tx_tb_top;
  localparam int MSC = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] data = '0;
  logic       valid = 1'b0;
  logic [1:0] len = '0;
  logic [2:0] par = '0;
  logic [1:0] stp = '0;
  logic [15:0] div = 16'd2;
  logic       pre4 = 1'b0;
  logic       bstart = 1'b0, bstop = 1'b0;
  logic [6:0] bms = '0;
  logic       tx, busy, sof, eos, ready;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  cfg_uart_tx #(.DIV_W(16), .MS_CYCLES(MSC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .valid_i(valid), .ready_o(ready),
    .cfg_len_i(len), .cfg_par_i(par), .cfg_stop_i(stp), .cfg_div_i(div),
    .cfg_pre4_i(pre4), .brk_start_i(bstart), .brk_ms_i(bms), .brk_stop_i(bstop),
    .tx_o(tx), .busy_o(busy), .sof_o(sof), .eos_o(eos)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // sends one frame and compares every cycle with a frame built here
  task automatic run_frame(input int l, input int p, input int s, input logic [7:0] d,
                           input int dv, input bit p4, input string tag, input bit mangle);
    int nb = l + 5;
    int pb = (p != 0) ? 1 : 0;
    int per = 2 * (p4 ? 4 : 1) * (dv == 0 ? 1 : dv);
    int sc = (s == 2) ? 2 * per : ((s == 1 && l == 0) ? per + per / 2 : per);
    int nfix = 1 + nb + pb;
    int tot = per * nfix + sc;
    logic [10:0] fb = '0;
    logic [7:0] md = d & (8'hFF >> (8 - nb));
    logic [2:0] op;
    int ol;
    fb[0] = 1'b0;
    for (int i = 0; i < nb; i++) fb[1 + i] = md[i];
    case (p)
      1: fb[1 + nb] = ^md;
      2: fb[1 + nb] = ~^md;
      3: fb[1 + nb] = 1'b1;
      default: fb[1 + nb] = 1'b0;
    endcase
    @(negedge clk);
    chk(ready === 1'b1, "R1 ready before frame", int'(ready), 1);
    len = 2'(l); par = 3'(p); stp = 2'(s); div = 16'(dv); pre4 = p4; data = d; valid = 1'b1;
    @(posedge clk);
    for (int n = 1; n <= tot + 1; n++) begin
      int c = n - 1;
      bit exp_tx;
      string rq;
      @(negedge clk);
      if (c >= tot) begin exp_tx = 1'b1; rq = "R1"; end
      else if (c < per * nfix) begin
        exp_tx = fb[c / per];
        rq = (c / per == nb + 1) ? "R3" : "R2";
      end else begin exp_tx = 1'b1; rq = "R4"; end
      if (tag != "") rq = tag;
      chk(tx === exp_tx, $sformatf("%s tx l=%0d p=%0d s=%0d n=%0d", rq, l, p, s, n), int'(tx), int'(exp_tx));
      chk(sof === (n == 1), "R7 sof", int'(sof), int'(n == 1));
      chk(eos === (n == tot), $sformatf("R4 eos l=%0d s=%0d n=%0d", l, s, n), int'(eos), int'(n == tot));
      chk(busy === (n <= tot), "R7 busy", int'(busy), int'(n <= tot));
      chk(ready === (n > tot), "R7 ready", int'(ready), int'(n > tot));
      if (n == 1) begin
        valid = 1'b0;
        if (mangle) begin
          ol = l; op = 3'(p);
          len = 2'(3 - ol); par = (op == 3'd3) ? 3'd4 : 3'd3; stp = 2'd2;
          div = 16'(dv + 3); pre4 = ~p4; data = ~d;
        end
      end
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(tx === 1'b1, "R1 tx idle", int'(tx), 1);
    chk(busy === 1'b0, "R1 busy", int'(busy), 0);
    chk(ready === 1'b1, "R1 ready", int'(ready), 1);
    chk(sof === 1'b0 && eos === 1'b0, "R1 strobes", int'(sof) + int'(eos), 0);
  endtask

  task automatic test_all_formats();
    for (int l = 0; l < 4; l++)
      for (int p = 0; p < 5; p++)
        for (int s = 0; s < 3; s++)
          run_frame(l, p, s, 8'(8'hA5 ^ (l * 61 + p * 23 + s * 7)), 2, 1'b0, "", 1'b0);
  endtask

  task automatic test_rates();
    run_frame(3, 1, 0, 8'h3C, 1, 1'b1, "R5 pre4", 1'b0);
    run_frame(0, 0, 1, 8'h15, 3, 1'b0, "R5 div3", 1'b0);
    run_frame(2, 2, 0, 8'h6B, 0, 1'b0, "R5 div0", 1'b0);
  endtask

  task automatic test_cfg_hold();
    run_frame(1, 3, 0, 8'h2E, 2, 1'b0, "R6", 1'b1);
    run_frame(0, 4, 1, 8'h19, 2, 1'b0, "R6", 1'b1);
  endtask

  task automatic test_brk_timed(input int ms);
    int eff = (ms > 125) ? 125 : ms;
    int lt = eff * MSC;
    @(negedge clk);
    bms = 7'(ms); bstart = 1'b1;
    @(posedge clk);
    for (int n = 1; n <= lt + 1; n++) begin
      @(negedge clk);
      if (n == 1) bstart = 1'b0;
      if (n == 1 || n == lt || n == lt / 2)
        chk(tx === 1'b0 && busy === 1'b1, $sformatf("R8 brk low ms=%0d n=%0d", ms, n), int'(tx), 0);
      if (n == lt + 1)
        chk(tx === 1'b1 && busy === 1'b0, $sformatf("R8 brk end ms=%0d", ms), int'(tx), 1);
      chk(sof === 1'b0, "R9 no sof in break", int'(sof), 0);
    end
  endtask

  task automatic test_brk_open();
    @(negedge clk);
    bms = 7'd0; bstart = 1'b1;
    @(posedge clk);
    for (int n = 1; n <= 41; n++) begin
      @(negedge clk);
      bstart = 1'b0;
      if (n <= 40) chk(tx === 1'b0, $sformatf("R9 open brk n=%0d", n), int'(tx), 0);
      if (n == 40) bstop = 1'b1;
      if (n == 41) begin
        chk(tx === 1'b1 && busy === 1'b0, "R9 open brk released", int'(tx), 1);
        bstop = 1'b0;
      end
    end
  endtask

  task automatic test_brk_wait();
    int per = 4;
    int tot = per * (1 + 8) + per;
    int lt = 2 * MSC;
    @(negedge clk);
    len = 2'd3; par = 3'd0; stp = 2'd0; div = 16'd2; pre4 = 1'b0; data = 8'h81; valid = 1'b1;
    bms = 7'd2;
    @(posedge clk);
    for (int n = 1; n <= tot + lt + 2; n++) begin
      @(negedge clk);
      if (n == 1) valid = 1'b0;
      if (n == 2) bstart = 1'b1;
      if (n == 3) begin
        bstart = 1'b0;
        chk(tx === 1'b0 && ready === 1'b0, "R10 frame continues", int'(tx), 0);
      end
      if (n == tot) chk(eos === 1'b1, "R10 eos on time", int'(eos), 1);
      if (n == tot + 1) chk(tx === 1'b1 && ready === 1'b0, "R10 gap cycle", int'(ready), 0);
      if (n == tot + 2) chk(tx === 1'b0, "R10 break begins", int'(tx), 0);
      if (n == tot + 1 + lt) chk(tx === 1'b0, "R10 break last", int'(tx), 0);
      if (n == tot + 2 + lt) chk(tx === 1'b1 && ready === 1'b1, "R10 break done", int'(tx), 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R1 watchdog expired act=0 exp=1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_all_formats();
    test_rates();
    test_cfg_hold();
    test_brk_timed(3);
    test_brk_timed(127);
    test_brk_open();
    test_brk_wait();
    summary();
    $finish;
  end
endmodule